// File: doc/BRIEF.md
# Text Cursor and Underline Overlay Generator

This block sits in the text-mode pixel path. For every dot it takes the scan row inside the current character cell, the dot column, the character code and its underline flag, and reports whether a cursor or underline overlay covers that dot. The cursor is a band of rows between a programmable first row and last row. It is drawn only in the cell flagged as the cursor position and only while the supplied blink phase is high. The underline is a single programmable row inside the cell. In 9-dot modes the ninth column is normally left out, which makes the underline dashed across adjacent characters. Line-graphics codes keep the ninth column, so their underline stays solid.

The block also holds the font-map select that the glyph fetch uses. A write only loads a shadow value. That value is copied to the active select when the row counter wraps back to row zero, which means a new font never starts partway through a character line. A small state machine with the states MAP_STEADY (nothing pending) and MAP_PENDING (shadow holds an unapplied value) controls this. It has four transitions:
- MAP_STEADY to MAP_PENDING on a write.
- MAP_PENDING to MAP_STEADY on a wrap with no write in that cycle.
- MAP_PENDING stays in MAP_PENDING on a write, or on a wrap that has a write in the same cycle.
- MAP_STEADY stays in MAP_STEADY otherwise.

Top module: `txt_overlay_gen`

## Requirements
- R1: After reset, `overlay_on` is 0 and `font_map` is 0.
- R2: `overlay_on` is 1 one clock after a cycle in which `cur_here` and `blink_on` are 1 and `cur_first` <= `row_cnt` <= `cur_last`.
- R3: When `cur_first` is greater than `cur_last`, the cursor contributes nothing on any row.
- R4: With `blink_on` at 0, the cursor contributes nothing.
- R5: With `nine_dot` at 0, an underlined character (`ul_attr`=1) sets `overlay_on` one clock later on every dot of the row equal to `ul_row`, and on no other row.
- R6: With `nine_dot` at 1, dot column 8 (the ninth, counted from 0) is not underlined for codes outside 0xC0..0xDF; columns 0..7 are underlined.
- R7: With `nine_dot` at 1, codes 0xC0 through 0xDF are underlined on dot column 8 as well.
- R8: A write (`map_wr`=1) does not change `font_map` until a wrap cycle. A wrap cycle is one in which `row_cnt` is 0 and was nonzero in the previous clocked cycle. `font_map` takes the pending value one clock after the wrap cycle. A write made while `row_cnt` stays at 0 waits for the next wrap.
- R9: A write in a wrap cycle is not applied at that wrap. Any value already pending is committed at that wrap, and the new value waits for the following wrap.
- R10: Several writes before one wrap: the last value written is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_cnt | input | ROW_W | Scan row inside the character cell |
| dot_cnt | input | DOT_W | Dot column inside the character cell |
| char_code | input | CODE_W | Character code of the current cell |
| ul_attr | input | 1 | Underline attribute of the current cell |
| cur_here | input | 1 | Current cell is the cursor position |
| cur_first | input | ROW_W | First cursor row |
| cur_last | input | ROW_W | Last cursor row |
| ul_row | input | ROW_W | Row that carries the underline |
| nine_dot | input | 1 | 1 for 9-dot cells, 0 for 8-dot cells |
| blink_on | input | 1 | Cursor blink phase |
| map_wr | input | 1 | Font-map select write strobe |
| map_wdata | input | MAP_W | Font-map select write value |
| overlay_on | output | 1 | Cursor or underline covers this dot (one clock latency) |
| font_map | output | MAP_W | Active font-map select |

## Verification
The collision that matters is a map-select write landing in the very cycle the row counter wraps to zero while an older value is still pending. The bench drives this by writing during a mid-cell row, running the rows up to the wrap, and issuing a second write on the wrap cycle. It then expects the older value to appear on `font_map` one clock later, and the newer value only after one more full character line. A second overlap is a cursor and an underline on the same dot, which must give a single overlay bit. The bench provokes it by placing `ul_row` inside the cursor band.

// File: rtl/txt_overlay_pkg.sv
package txt_overlay_pkg;
    typedef enum logic {
        MAP_STEADY  = 1'b0,
        MAP_PENDING = 1'b1
    } map_state_t;

    localparam logic [2:0] LINE_GFX_TOP = 3'b110;
endpackage

// File: rtl/cursor_band.sv
module cursor_band #(
    parameter int ROW_W = 5
) (
    input  logic [ROW_W-1:0] row_cnt,
    input  logic [ROW_W-1:0] cur_first,
    input  logic [ROW_W-1:0] cur_last,
    input  logic             cur_here,
    input  logic             blink_on,
    output logic             cursor_hit
);
    logic band_valid;
    logic in_band;

    always_comb begin
        band_valid = (cur_first <= cur_last);
        in_band    = (row_cnt >= cur_first) && (row_cnt <= cur_last);
        cursor_hit = cur_here && blink_on && band_valid && in_band;
    end
endmodule

// File: rtl/underline_mask.sv
module underline_mask
    import txt_overlay_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int DOT_W  = 4,
    parameter int CODE_W = 8
) (
    input  logic [ROW_W-1:0]  row_cnt,
    input  logic [ROW_W-1:0]  ul_row,
    input  logic [DOT_W-1:0]  dot_cnt,
    input  logic [CODE_W-1:0] char_code,
    input  logic              ul_attr,
    input  logic              nine_dot,
    output logic              underline_hit
);
    localparam logic [DOT_W-1:0] NINTH_COL = DOT_W'(8);

    logic line_gfx;
    logic col_ok;

    always_comb begin
        line_gfx      = (char_code[CODE_W-1 -: 3] == LINE_GFX_TOP);
        col_ok        = !nine_dot || (dot_cnt != NINTH_COL) || line_gfx;
        underline_hit = ul_attr && (row_cnt == ul_row) && col_ok;
    end
endmodule

// File: rtl/map_select_fsm.sv
module map_select_fsm
    import txt_overlay_pkg::*;
#(
    parameter int ROW_W = 5,
    parameter int MAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row_cnt,
    input  logic             map_wr,
    input  logic [MAP_W-1:0] map_wdata,
    output logic [MAP_W-1:0] font_map
);
    map_state_t       state_q, state_d;
    logic [ROW_W-1:0] prev_row_q;
    logic [MAP_W-1:0] shadow_q;
    logic [MAP_W-1:0] active_q;
    logic             wrap;

    assign wrap = (row_cnt == '0) && (prev_row_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_STEADY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_STEADY:  if (map_wr) state_d = MAP_PENDING;
            MAP_PENDING: if (wrap && !map_wr) state_d = MAP_STEADY;
            default:     state_d = MAP_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_row_q <= '0;
            shadow_q   <= '0;
            active_q   <= '0;
        end else begin
            prev_row_q <= row_cnt;
            if (state_q == MAP_PENDING && wrap) active_q <= shadow_q;
            if (map_wr) shadow_q <= map_wdata;
        end
    end

    assign font_map = active_q;
endmodule

// File: rtl/txt_overlay_gen.sv
module txt_overlay_gen
    import txt_overlay_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int DOT_W  = 4,
    parameter int CODE_W = 8,
    parameter int MAP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  row_cnt,
    input  logic [DOT_W-1:0]  dot_cnt,
    input  logic [CODE_W-1:0] char_code,
    input  logic              ul_attr,
    input  logic              cur_here,
    input  logic [ROW_W-1:0]  cur_first,
    input  logic [ROW_W-1:0]  cur_last,
    input  logic [ROW_W-1:0]  ul_row,
    input  logic              nine_dot,
    input  logic              blink_on,
    input  logic              map_wr,
    input  logic [MAP_W-1:0]  map_wdata,
    output logic              overlay_on,
    output logic [MAP_W-1:0]  font_map
);
    logic cursor_hit;
    logic underline_hit;

    cursor_band #(.ROW_W(ROW_W)) u_cursor (
        .row_cnt    (row_cnt),
        .cur_first  (cur_first),
        .cur_last   (cur_last),
        .cur_here   (cur_here),
        .blink_on   (blink_on),
        .cursor_hit (cursor_hit)
    );

    underline_mask #(.ROW_W(ROW_W), .DOT_W(DOT_W), .CODE_W(CODE_W)) u_ul (
        .row_cnt       (row_cnt),
        .ul_row        (ul_row),
        .dot_cnt       (dot_cnt),
        .char_code     (char_code),
        .ul_attr       (ul_attr),
        .nine_dot      (nine_dot),
        .underline_hit (underline_hit)
    );

    map_select_fsm #(.ROW_W(ROW_W), .MAP_W(MAP_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_cnt   (row_cnt),
        .map_wr    (map_wr),
        .map_wdata (map_wdata),
        .font_map  (font_map)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) overlay_on <= 1'b0;
        else        overlay_on <= cursor_hit || underline_hit;
    end
endmodule

// File: rtl/txt_overlay_chk.sv
module txt_overlay_chk #(
    parameter int ROW_W  = 5,
    parameter int DOT_W  = 4,
    parameter int CODE_W = 8,
    parameter int MAP_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROW_W-1:0]  row_cnt,
    input logic [DOT_W-1:0]  dot_cnt,
    input logic [CODE_W-1:0] char_code,
    input logic              ul_attr,
    input logic              cur_here,
    input logic [ROW_W-1:0]  cur_first,
    input logic [ROW_W-1:0]  cur_last,
    input logic              nine_dot,
    input logic              blink_on,
    input logic              overlay_on,
    input logic [MAP_W-1:0]  font_map
);
    logic [ROW_W-1:0] seen_row;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_row <= '0;
        else        seen_row <= row_cnt;
    end

    a_r3_inverted_band_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_first > cur_last && !ul_attr) |=> !overlay_on);

    a_r4_blink_low_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!blink_on && !ul_attr) |=> !overlay_on);

    a_r6_ninth_col_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_dot && dot_cnt == DOT_W'(8) && char_code[CODE_W-1 -: 3] != 3'b110
         && !cur_here) |=> !overlay_on);

    a_r2_no_source_no_overlay: assert property (@(posedge clk) disable iff (!rst_n)
        (!ul_attr && !cur_here) |=> !overlay_on);

    a_r8_map_changes_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_cnt == '0 && seen_row != '0) |=> $stable(font_map));
endmodule

bind txt_overlay_gen txt_overlay_chk #(
    .ROW_W(ROW_W), .DOT_W(DOT_W), .CODE_W(CODE_W), .MAP_W(MAP_W)
) u_chk (.*);

// File: tb/txt_overlay_gen_bench.sv
module txt_overlay_gen_bench;
    localparam int ROW_W = 5, DOT_W = 4, CODE_W = 8, MAP_W = 3;

    logic clk = 0, rst_n = 0;
    logic [ROW_W-1:0] row_cnt = 0, cur_first = 0, cur_last = 0, ul_row = 0;
    logic [DOT_W-1:0] dot_cnt = 0;
    logic [CODE_W-1:0] char_code = 0;
    logic ul_attr = 0, cur_here = 0, nine_dot = 0, blink_on = 0, map_wr = 0;
    logic [MAP_W-1:0] map_wdata = 0;
    logic overlay_on;
    logic [MAP_W-1:0] font_map;

    always #5 clk = ~clk;

    txt_overlay_gen u_txt_overlay_gen (.*);

    typedef struct {
        string          tag;
        logic           ov;
        logic [MAP_W-1:0] map;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    logic [ROW_W-1:0] m_prev = 0;
    logic [MAP_W-1:0] m_active = 0, m_shadow = 0;
    logic m_pend = 0;

    task automatic step(input string tag);
        exp_t e;
        logic cur, ul, wrap;
        cur = cur_here && blink_on && row_cnt >= cur_first && row_cnt <= cur_last;
        ul  = ul_attr && row_cnt == ul_row &&
              (!nine_dot || dot_cnt != 8 || (char_code >= 8'hC0 && char_code <= 8'hDF));
        wrap = (row_cnt == 0) && (m_prev != 0);
        if (m_pend && wrap) m_active = m_shadow;
        if (map_wr) begin m_shadow = map_wdata; m_pend = 1; end
        else if (wrap) m_pend = 0;
        m_prev = row_cnt;
        e.tag = tag; e.ov = cur || ul; e.map = m_active;
        q.push_back(e);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (overlay_on !== e.ov || font_map !== e.map) begin
                errors++;
                $display("FAIL %s: overlay=%b map=%0d expected overlay=%b map=%0d",
                         e.tag, overlay_on, font_map, e.ov, e.map);
            end
        end
    end

    task automatic run_rows(input string tag, input int from, input int to);
        for (int r = from; r <= to; r++) begin
            row_cnt = ROW_W'(r);
            step(tag);
        end
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (overlay_on !== 1'b0 || font_map !== '0) begin
            errors++;
            $display("FAIL R1: overlay=%b map=%0d expected overlay=0 map=0", overlay_on, font_map);
        end
        rst_n = 1;
        @(negedge clk);

        // R2: cursor band rows 3..5
        cur_here = 1; blink_on = 1; cur_first = 3; cur_last = 5; ul_row = 7;
        run_rows("R2", 0, 7);
        // R3: inverted band
        cur_first = 6; cur_last = 2;
        run_rows("R3", 0, 7);
        // R4: blink phase low
        cur_first = 0; cur_last = 7; blink_on = 0;
        run_rows("R4", 0, 7);
        // cursor and underline on the same dot
        blink_on = 1; ul_attr = 1; ul_row = 4; row_cnt = 4;
        step("R2");
        cur_here = 0; blink_on = 0;
        // R5: 8-dot underline on every column
        ul_row = 7; nine_dot = 0; char_code = 8'h41;
        for (int d = 0; d < 8; d++) begin dot_cnt = DOT_W'(d); row_cnt = 7; step("R5"); end
        for (int r = 0; r < 7; r++) begin dot_cnt = 2; row_cnt = ROW_W'(r); step("R5"); end
        // R6: 9-dot, ordinary codes leave column 8 blank
        nine_dot = 1; row_cnt = 7;
        for (int d = 0; d < 9; d++) begin dot_cnt = DOT_W'(d); step("R6"); end
        char_code = 8'hBF; dot_cnt = 8; step("R6");
        char_code = 8'hE0; step("R6");
        // R7: line-graphics codes keep column 8
        char_code = 8'hC0; step("R7");
        char_code = 8'hC4; step("R7");
        char_code = 8'hDF; step("R7");
        ul_attr = 0; dot_cnt = 0; row_cnt = 0;
        step("R7");

        // R8: write during row 0 waits for a real wrap
        map_wr = 1; map_wdata = 5; step("R8");
        map_wr = 0; step("R8");
        run_rows("R8", 1, 7);
        run_rows("R8", 0, 2);
        // R10: last of several writes wins
        map_wr = 1; map_wdata = 2; row_cnt = 3; step("R10");
        map_wdata = 6; row_cnt = 4; step("R10");
        map_wr = 0;
        run_rows("R10", 5, 7);
        run_rows("R10", 0, 1);
        // R9: write on the wrap cycle with a value pending
        map_wr = 1; map_wdata = 1; row_cnt = 3; step("R9");
        map_wr = 0;
        run_rows("R9", 4, 7);
        map_wr = 1; map_wdata = 4; row_cnt = 0; step("R9");
        map_wr = 0;
        run_rows("R9", 1, 7);
        run_rows("R9", 0, 1);
        // R9: write on a wrap with nothing pending
        run_rows("R9", 2, 7);
        map_wr = 1; map_wdata = 3; row_cnt = 0; step("R9");
        map_wr = 0;
        run_rows("R9", 1, 7);
        run_rows("R9", 0, 1);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule